// File: doc/BRIEF.md
# Reservation Station with Result Wakeup

This block is the waiting room in front of one execution unit of an out-of-order core. A decoder hands it instructions, one per cycle, through a valid/ready dispatch port. Each instruction carries an opcode, the physical register it will write, and two source operands. A source that is already known arrives as a value. A source that is still being computed arrives as the tag of its producer and is marked as waiting.

The station snoops a result broadcast bus (tag plus value) every cycle. When a broadcast tag equals the tag a waiting source holds, the station copies the value into that source and marks it available. This includes a broadcast that appears in the very cycle the dependent instruction is dispatched. Any entry whose two sources are both available may go to the execution unit through a valid/ready issue port. Program order does not decide this, so a stalled older entry never holds back a younger one. When several entries are eligible, the earliest dispatched one is chosen. Each entry keeps a small age rank for this purpose.

The station has eight slots by default. It refuses dispatch while every slot is occupied. A slot that issues is free again one cycle after its issue handshake. A flush input empties the whole station in one cycle.

Top module: `wake_rs`

## Requirements
- R1: A dispatch is accepted when `disp_valid` and `disp_ready` are both high. A source whose ready flag is 1 at dispatch is stored as a value and later appears unchanged on `iss_a` / `iss_b`.
- R2: A waiting source takes `bc_val` and becomes available when `bc_valid` is high and `bc_tag` equals its stored tag. A broadcast with any other tag leaves it waiting.
- R3: An entry is offered on the issue port only when both of its sources are available. A waiting entry never prevents an available entry from issuing, whatever their dispatch order.
- R4: When the issue port makes a fresh choice among several eligible entries, it picks the one dispatched earliest, regardless of the slot each one occupies.
- R5: A broadcast whose tag matches a waiting source of the instruction being dispatched in the same cycle is captured into the new entry.
- R6: `disp_ready` is low whenever all `DEPTH` slots hold entries. It stays low during the issue handshake cycle of a full station and rises in the following cycle.
- R7: While `flush` is high, `disp_ready` and `iss_valid` are low and no dispatch is taken. From the next cycle on, the station holds no entries.
- R8: While `iss_valid` is high and `iss_ready` is low, the offered entry stays on the issue port unchanged, even if an older entry becomes eligible meanwhile.
- R9: After reset the station is empty: `disp_ready` is high and `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Discard every entry |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Station can take a dispatch this cycle |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | TAG_W | Destination tag of the dispatched instruction |
| disp_a_rdy | input | 1 | Source A is supplied as a value |
| disp_a_tag | input | TAG_W | Producer tag of source A |
| disp_a_val | input | DATA_W | Value of source A |
| disp_b_rdy | input | 1 | Source B is supplied as a value |
| disp_b_tag | input | TAG_W | Producer tag of source B |
| disp_b_val | input | DATA_W | Value of source B |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | An entry is offered to the execution unit |
| iss_ready | input | 1 | Execution unit takes the offered entry |
| iss_op | output | OP_W | Opcode of the offered entry |
| iss_dst | output | TAG_W | Destination tag of the offered entry |
| iss_a | output | DATA_W | Source A value of the offered entry |
| iss_b | output | DATA_W | Source B value of the offered entry |

## Verification
The bench builds the station with its defaults: eight slots, 6-bit tags, 32-bit values and 4-bit opcodes. With eight slots the full condition is reached after eight dispatches, so the backpressure edge and the free-slot timing are both exercised. Freeing a low slot while a higher slot still waits brings the case where a younger entry lands in a lower-numbered slot than an older one. That is the case that separates age order from slot order. With 6-bit tags the bench can hold several distinct producers in flight and broadcast near-miss tags to show that they are ignored.

// File: rtl/wake_rs_pkg.sv
`timescale 1ns/1ps
// Package wake_rs_pkg
// Shared default sizes for the reservation station and its helpers.
// Assumes all users take their parameter defaults from here.
package wake_rs_pkg;
    localparam int DEPTH_DEF  = 8;
    localparam int TAG_W_DEF  = 6;
    localparam int DATA_W_DEF = 32;
    localparam int OP_W_DEF   = 4;
endpackage

// File: rtl/wake_rs_src.sv
`timescale 1ns/1ps
// Module wake_rs_src
// One source operand of a station entry: either a held value or a producer
// tag waiting for a matching broadcast. Captures a broadcast that coincides
// with its own load. Assumes load is only pulsed for a free slot.
module wake_rs_src #(
    parameter int TAG_W  = wake_rs_pkg::TAG_W_DEF,
    parameter int DATA_W = wake_rs_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_rdy,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              rdy,
    output logic [DATA_W-1:0] val
);
    logic [TAG_W-1:0] tag;
    logic             ld_hit;
    logic             wait_hit;

    // Detect broadcast matches for the incoming and the stored tag
    always_comb begin
        ld_hit   = !ld_rdy && bc_valid && (bc_tag == ld_tag);
        wait_hit = !rdy && bc_valid && (bc_tag == tag);
    end

    // Load a new operand or capture a broadcast into a waiting one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0;
            tag <= '0;
            val <= '0;
        end else if (load) begin
            tag <= ld_tag;
            rdy <= ld_rdy || ld_hit;
            val <= ld_hit ? bc_val : ld_val;
        end else if (wait_hit) begin
            rdy <= 1'b1;
            val <= bc_val;
        end
    end
endmodule

// File: rtl/wake_rs_slot.sv
`timescale 1ns/1ps
// Module wake_rs_slot
// One station entry: valid flag, opcode, destination, age rank and two
// source operands. The rank counts how many live entries are older; it is
// lowered by one when an older entry leaves. Assumes wr_en and clr are never
// both high, and that flush wins over everything.
module wake_rs_slot #(
    parameter int OP_W   = wake_rs_pkg::OP_W_DEF,
    parameter int TAG_W  = wake_rs_pkg::TAG_W_DEF,
    parameter int DATA_W = wake_rs_pkg::DATA_W_DEF,
    parameter int RANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [OP_W-1:0]   wr_op,
    input  logic [TAG_W-1:0]  wr_dst,
    input  logic [RANK_W-1:0] wr_rank,
    input  logic              wr_a_rdy,
    input  logic [TAG_W-1:0]  wr_a_tag,
    input  logic [DATA_W-1:0] wr_a_val,
    input  logic              wr_b_rdy,
    input  logic [TAG_W-1:0]  wr_b_tag,
    input  logic [DATA_W-1:0] wr_b_val,
    input  logic              clr,
    input  logic              dec,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              valid,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dst,
    output logic [RANK_W-1:0] rank,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    logic a_rdy;
    logic b_rdy;

    wake_rs_src #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_a (
        .clk(clk), .rst_n(rst_n), .load(wr_en),
        .ld_rdy(wr_a_rdy), .ld_tag(wr_a_tag), .ld_val(wr_a_val),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .rdy(a_rdy), .val(a_val)
    );

    wake_rs_src #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_b (
        .clk(clk), .rst_n(rst_n), .load(wr_en),
        .ld_rdy(wr_b_rdy), .ld_tag(wr_b_tag), .ld_val(wr_b_val),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .rdy(b_rdy), .val(b_val)
    );

    // Entry is eligible once it lives and both operands are present
    assign ready = valid && a_rdy && b_rdy;

    // Track occupancy, entry fields and age rank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            op    <= '0;
            dst   <= '0;
            rank  <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (wr_en) begin
            valid <= 1'b1;
            op    <= wr_op;
            dst   <= wr_dst;
            rank  <= wr_rank;
        end else begin
            if (clr) begin
                valid <= 1'b0;
            end
            if (dec && valid) begin
                rank <= rank - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wake_rs_pick.sv
`timescale 1ns/1ps
// Module wake_rs_pick
// Chooses, among eligible entries, the one with the smallest age rank.
// Assumes ranks of live entries are distinct, so the choice is unique.
module wake_rs_pick #(
    parameter int DEPTH  = wake_rs_pkg::DEPTH_DEF,
    parameter int RANK_W = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             cand,
    input  logic [DEPTH-1:0][RANK_W-1:0] rank,
    output logic                         any,
    output logic [IDX_W-1:0]             idx
);
    logic [RANK_W-1:0] best;

    // Linear scan keeping the oldest eligible entry seen so far
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand[i] && (!any || rank[i] < best)) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = rank[i];
            end
        end
    end
endmodule

// File: rtl/wake_rs.sv
`timescale 1ns/1ps
// Module wake_rs
// Reservation station for one execution unit. Takes instructions with
// value-or-tag sources, wakes sources from a result broadcast, and issues
// the oldest entry whose sources are all present. An offered entry is held
// on the issue port until taken. Flush empties the station in one cycle.
// Assumes DEPTH is a power of two and at least 2.
module wake_rs #(
    parameter int DEPTH  = wake_rs_pkg::DEPTH_DEF,
    parameter int TAG_W  = wake_rs_pkg::TAG_W_DEF,
    parameter int DATA_W = wake_rs_pkg::DATA_W_DEF,
    parameter int OP_W   = wake_rs_pkg::OP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic              disp_a_rdy,
    input  logic [TAG_W-1:0]  disp_a_tag,
    input  logic [DATA_W-1:0] disp_a_val,
    input  logic              disp_b_rdy,
    input  logic [TAG_W-1:0]  disp_b_tag,
    input  logic [DATA_W-1:0] disp_b_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int RANK_W = IDX_W;
    localparam int CNT_W  = IDX_W + 1;

    logic [DEPTH-1:0]              ent_valid;
    logic [DEPTH-1:0]              ent_ready;
    logic [DEPTH-1:0][OP_W-1:0]    ent_op;
    logic [DEPTH-1:0][TAG_W-1:0]   ent_dst;
    logic [DEPTH-1:0][RANK_W-1:0]  ent_rank;
    logic [DEPTH-1:0][DATA_W-1:0]  ent_a;
    logic [DEPTH-1:0][DATA_W-1:0]  ent_b;

    logic [IDX_W-1:0]  free_idx;
    logic [CNT_W-1:0]  occ;
    logic [RANK_W-1:0] new_rank;
    logic              disp_fire;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic              hold;
    logic [IDX_W-1:0]  hold_idx;
    logic [IDX_W-1:0]  sel_idx;
    logic [RANK_W-1:0] sel_rank;
    logic              iss_fire;

    // Lowest-numbered free slot receives the next dispatch
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    // Count occupied slots to give a new entry its age rank
    always_comb begin
        occ = '0;
        for (int i = 0; i < DEPTH; i++) begin
            occ = occ + CNT_W'(ent_valid[i]);
        end
    end

    // Dispatch handshake: refuse when full or flushing
    assign disp_ready = !(&ent_valid) && !flush;
    assign disp_fire  = disp_valid && disp_ready;

    // A new entry is younger than every entry that stays
    assign new_rank = RANK_W'(occ - CNT_W'(iss_fire));

    wake_rs_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W)) u_pick (
        .cand(ent_ready),
        .rank(ent_rank),
        .any(pick_any),
        .idx(pick_idx)
    );

    // Remember a stalled offer so it stays on the port until taken
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hold     <= 1'b0;
            hold_idx <= '0;
        end else begin
            hold     <= iss_valid && !iss_ready;
            hold_idx <= sel_idx;
        end
    end

    // Issue port: held entry first, otherwise the oldest eligible one
    assign sel_idx   = hold ? hold_idx : pick_idx;
    assign sel_rank  = ent_rank[sel_idx];
    assign iss_valid = !flush && (hold || pick_any);
    assign iss_fire  = iss_valid && iss_ready;
    assign iss_op    = ent_op[sel_idx];
    assign iss_dst   = ent_dst[sel_idx];
    assign iss_a     = ent_a[sel_idx];
    assign iss_b     = ent_b[sel_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        wake_rs_slot #(
            .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .RANK_W(RANK_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (disp_fire && (free_idx == IDX_W'(g))),
            .wr_op    (disp_op),
            .wr_dst   (disp_dst),
            .wr_rank  (new_rank),
            .wr_a_rdy (disp_a_rdy),
            .wr_a_tag (disp_a_tag),
            .wr_a_val (disp_a_val),
            .wr_b_rdy (disp_b_rdy),
            .wr_b_tag (disp_b_tag),
            .wr_b_val (disp_b_val),
            .clr      (iss_fire && (sel_idx == IDX_W'(g))),
            .dec      (iss_fire && (ent_rank[g] > sel_rank)),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_val   (bc_val),
            .valid    (ent_valid[g]),
            .ready    (ent_ready[g]),
            .op       (ent_op[g]),
            .dst      (ent_dst[g]),
            .rank     (ent_rank[g]),
            .a_val    (ent_a[g]),
            .b_val    (ent_b[g])
        );
    end
endmodule

// File: rtl/wake_rs_chk.sv
`timescale 1ns/1ps
// Module wake_rs_chk
// Protocol and occupancy properties of the reservation station, attached
// to every wake_rs instance by the bind below.
module wake_rs_chk #(
    parameter int DEPTH  = wake_rs_pkg::DEPTH_DEF,
    parameter int TAG_W  = wake_rs_pkg::TAG_W_DEF,
    parameter int DATA_W = wake_rs_pkg::DATA_W_DEF,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              disp_ready,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [TAG_W-1:0]  iss_dst,
    input logic [DATA_W-1:0] iss_a,
    input logic [DATA_W-1:0] iss_b,
    input logic [DEPTH-1:0]  ent_valid,
    input logic [IDX_W-1:0]  sel_idx
);
    // R6
    full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&ent_valid) |-> !disp_ready);

    // R6
    issued_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> !ent_valid[$past(sel_idx)]);

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_dst)
                                       && $stable(iss_a) && $stable(iss_b)));
endmodule

bind wake_rs wake_rs_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake_rs_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_ready(disp_ready),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_dst(iss_dst),
    .iss_a(iss_a), .iss_b(iss_b), .ent_valid(ent_valid), .sel_idx(sel_idx)
);

// File: tb/wake_rs_bench.sv
`timescale 1ns/1ps
// Bench for wake_rs: a driver pushes expected issue items into a queue,
// a monitor pops and compares each item the station hands out.
module wake_rs_bench;
    localparam int DEPTH  = 8;
    localparam int TAG_W  = 6;
    localparam int DATA_W = 32;
    localparam int OP_W   = 4;
    localparam int ITEM_W = OP_W + TAG_W + 2 * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n, flush, disp_valid, disp_ready;
    logic [OP_W-1:0]   disp_op;
    logic [TAG_W-1:0]  disp_dst, disp_a_tag, disp_b_tag, bc_tag;
    logic [DATA_W-1:0] disp_a_val, disp_b_val, bc_val;
    logic              disp_a_rdy, disp_b_rdy, bc_valid;
    logic              iss_valid, iss_ready;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_dst;
    logic [DATA_W-1:0] iss_a, iss_b;

    logic [ITEM_W-1:0] exp_q[$];
    string             req_q[$];
    int                n_chk = 0;
    int                n_bad = 0;
    bit                done  = 1'b0;

    initial forever #2.5 clk = ~clk;

    wake_rs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_wake_rs (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
        .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b)
    );

    task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: one dispatch, handshake checked at the negative edge
    task automatic dispatch(logic [OP_W-1:0] op, logic [TAG_W-1:0] dst,
                            logic ar, logic [TAG_W-1:0] at, logic [DATA_W-1:0] av,
                            logic br, logic [TAG_W-1:0] bt, logic [DATA_W-1:0] bv);
        disp_op = op; disp_dst = dst;
        disp_a_rdy = ar; disp_a_tag = at; disp_a_val = av;
        disp_b_rdy = br; disp_b_tag = bt; disp_b_val = bv;
        disp_valid = 1'b1;
        @(negedge clk);
        check_eq("R1", "disp_ready at dispatch", 64'(disp_ready), 64'd1);
        tick();
        disp_valid = 1'b0;
    endtask

    task automatic expect_iss(logic [OP_W-1:0] op, logic [TAG_W-1:0] dst,
                              logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, string req);
        exp_q.push_back({op, dst, a, b});
        req_q.push_back(req);
    endtask

    task automatic bcast(logic [TAG_W-1:0] tag, logic [DATA_W-1:0] val);
        bc_valid = 1'b1; bc_tag = tag; bc_val = val;
        tick();
        bc_valid = 1'b0;
    endtask

    // Monitor: every issue handshake pops and compares one expected item
    always @(negedge clk) begin
        if (rst_n && iss_valid && iss_ready) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R3 unexpected issue: got %0h expected none",
                         {iss_op, iss_dst, iss_a, iss_b});
            end else begin
                logic [ITEM_W-1:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if ({iss_op, iss_dst, iss_a, iss_b} !== e) begin
                    n_bad++;
                    $display("FAIL %s issued item: got %0h expected %0h",
                             r, {iss_op, iss_dst, iss_a, iss_b}, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; disp_valid = 1'b0; iss_ready = 1'b0;
        disp_op = '0; disp_dst = '0; disp_a_rdy = 1'b0; disp_a_tag = '0; disp_a_val = '0;
        disp_b_rdy = 1'b0; disp_b_tag = '0; disp_b_val = '0;
        bc_valid = 1'b0; bc_tag = '0; bc_val = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check_eq("R9", "disp_ready after reset", 64'(disp_ready), 64'd1);
        check_eq("R9", "iss_valid after reset", 64'(iss_valid), 64'd0);
        tick();

        // R1 ready-at-dispatch values pass through
        dispatch(4'h1, 6'h01, 1'b1, 6'h00, 32'hA5A5_0001, 1'b1, 6'h00, 32'h5A5A_0002);
        expect_iss(4'h1, 6'h01, 32'hA5A5_0001, 32'h5A5A_0002, "R1");
        iss_ready = 1'b1;
        repeat (3) tick();
        iss_ready = 1'b0;

        // R3 waiting older entry does not block a younger ready one
        dispatch(4'h2, 6'h02, 1'b0, 6'h0A, 32'h0, 1'b1, 6'h00, 32'h0000_0022);
        dispatch(4'h3, 6'h03, 1'b1, 6'h00, 32'h0000_0033, 1'b1, 6'h00, 32'h0000_0034);
        expect_iss(4'h3, 6'h03, 32'h0000_0033, 32'h0000_0034, "R3");
        iss_ready = 1'b1;
        tick();
        // R2 wakeup on matching tag
        expect_iss(4'h2, 6'h02, 32'hCAFE_000A, 32'h0000_0022, "R2");
        bcast(6'h0A, 32'hCAFE_000A);
        repeat (3) tick();

        // R2 non-matching tag ignored, two sources woken in different cycles
        dispatch(4'h4, 6'h04, 1'b0, 6'h28, 32'h0, 1'b0, 6'h29, 32'h0);
        bcast(6'h2A, 32'hDEAD_0000);
        @(negedge clk);
        check_eq("R2", "iss_valid after near-miss tag", 64'(iss_valid), 64'd0);
        tick();
        bcast(6'h29, 32'h0000_0B29);
        @(negedge clk);
        check_eq("R3", "iss_valid with one source waiting", 64'(iss_valid), 64'd0);
        tick();
        expect_iss(4'h4, 6'h04, 32'h0000_0A28, 32'h0000_0B29, "R2");
        bcast(6'h28, 32'h0000_0A28);
        repeat (3) tick();
        iss_ready = 1'b0;

        // R4 age order beats slot order
        dispatch(4'h5, 6'h05, 1'b1, 6'h00, 32'h55, 1'b1, 6'h00, 32'h56);
        dispatch(4'h6, 6'h06, 1'b0, 6'h14, 32'h0, 1'b1, 6'h00, 32'h66);
        expect_iss(4'h5, 6'h05, 32'h55, 32'h56, "R4");
        iss_ready = 1'b1;
        tick();
        iss_ready = 1'b0;
        dispatch(4'h7, 6'h07, 1'b0, 6'h14, 32'h0, 1'b1, 6'h00, 32'h77);
        bcast(6'h14, 32'h0000_1414);
        expect_iss(4'h6, 6'h06, 32'h0000_1414, 32'h66, "R4");
        expect_iss(4'h7, 6'h07, 32'h0000_1414, 32'h77, "R4");
        iss_ready = 1'b1;
        repeat (3) tick();
        iss_ready = 1'b0;

        // R5 broadcast in the dispatch cycle is captured
        bc_valid = 1'b1; bc_tag = 6'h21; bc_val = 32'h0000_2121;
        dispatch(4'h8, 6'h08, 1'b1, 6'h00, 32'h88, 1'b0, 6'h21, 32'h0);
        bc_valid = 1'b0;
        expect_iss(4'h8, 6'h08, 32'h88, 32'h0000_2121, "R5");
        iss_ready = 1'b1;
        repeat (3) tick();
        iss_ready = 1'b0;

        // R8 stalled offer holds while an older entry wakes
        dispatch(4'h9, 6'h09, 1'b0, 6'h3C, 32'h0, 1'b1, 6'h00, 32'h99);
        dispatch(4'hA, 6'h0A, 1'b1, 6'h00, 32'hAA, 1'b1, 6'h00, 32'hAB);
        @(negedge clk);
        check_eq("R8", "offered dst while stalled", 64'(iss_dst), 64'h0A);
        tick();
        bcast(6'h3C, 32'h0000_3C3C);
        @(negedge clk);
        check_eq("R8", "offered dst after older wakes", 64'(iss_dst), 64'h0A);
        check_eq("R8", "iss_valid held", 64'(iss_valid), 64'd1);
        expect_iss(4'hA, 6'h0A, 32'hAA, 32'hAB, "R8");
        expect_iss(4'h9, 6'h09, 32'h0000_3C3C, 32'h99, "R4");
        iss_ready = 1'b1;
        repeat (3) tick();
        iss_ready = 1'b0;

        // R6 full station backpressure and slot release timing
        for (int i = 0; i < DEPTH; i++) begin
            dispatch(4'hB, 6'(8'h30 + i), 1'b1, 6'h00, 32'(32'h100 + i), 1'b1, 6'h00, 32'(32'h200 + i));
        end
        @(negedge clk);
        check_eq("R6", "disp_ready when full", 64'(disp_ready), 64'd0);
        for (int i = 0; i < DEPTH; i++) begin
            expect_iss(4'hB, 6'(8'h30 + i), 32'(32'h100 + i), 32'(32'h200 + i), "R6");
        end
        tick();
        iss_ready = 1'b1;
        @(negedge clk);
        check_eq("R6", "disp_ready in issue handshake cycle", 64'(disp_ready), 64'd0);
        tick();
        @(negedge clk);
        check_eq("R6", "disp_ready after slot freed", 64'(disp_ready), 64'd1);
        repeat (DEPTH + 1) tick();
        iss_ready = 1'b0;

        // R7 flush drops entries and refuses dispatch
        dispatch(4'hC, 6'h11, 1'b1, 6'h00, 32'h1, 1'b1, 6'h00, 32'h2);
        dispatch(4'hC, 6'h12, 1'b0, 6'h15, 32'h0, 1'b1, 6'h00, 32'h3);
        dispatch(4'hC, 6'h13, 1'b1, 6'h00, 32'h4, 1'b1, 6'h00, 32'h5);
        flush = 1'b1;
        disp_valid = 1'b1; disp_op = 4'hD; disp_dst = 6'h14;
        disp_a_rdy = 1'b1; disp_b_rdy = 1'b1;
        @(negedge clk);
        check_eq("R7", "disp_ready during flush", 64'(disp_ready), 64'd0);
        check_eq("R7", "iss_valid during flush", 64'(iss_valid), 64'd0);
        tick();
        flush = 1'b0; disp_valid = 1'b0;
        @(negedge clk);
        check_eq("R7", "iss_valid after flush", 64'(iss_valid), 64'd0);
        check_eq("R7", "disp_ready after flush", 64'(disp_ready), 64'd1);
        tick();
        iss_ready = 1'b1;
        bcast(6'h15, 32'h0000_1515);
        repeat (3) tick();
        @(negedge clk);
        check_eq("R7", "no issue from flushed entries", 64'(iss_valid), 64'd0);
        tick();
        iss_ready = 1'b0;

        check_eq("R3", "expected issues left over", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule